// File: doc/BRIEF.md
# Single-Cycle Register-to-Register Add/Subtract Datapath

This block executes one 32-bit register-to-register instruction every clock cycle. Each cycle it takes the instruction word on its input and splits it into fields. It reads two source registers and adds or subtracts them. On the next rising edge it writes the result into a destination register. There is no control decoder: the six opcode bits are the control lines themselves. They choose the destination field, the second ALU operand, the ALU operation and the write-back source.

The register bank holds thirty-two words, and after reset entry i holds the value i. The ALU result is a combinational output for the instruction being presented now. Register 1 is brought out on a probe port so that results can be watched from outside. The write-back path can only choose between the ALU result and a constant zero that stands in for memory data. Fetch, program counter and data memory belong to the surrounding design.

Top module: `rtype_datapath`

## Requirements
- R1: Instruction fields are taken from fixed positions: opcode in bits 31:26, first source rs in bits 25:21, second source rt in bits 20:16, destination rd in bits 15:11, and a 16-bit immediate in bits 15:0. Opcode bit 5 selects rd (1) or rt (0) as write address, bit 4 selects the immediate (1) or rt's register (0) as second operand, bits 3:1 are the ALU code, and bit 0 selects write-back of zero (1) or of the ALU result (0).
- R2: While reset (rst_n low) is asserted, and until a later write changes it, register entry i holds the value i.
- R3: ALU code 3'b010 makes alu_result equal to reg[rs] + operand B, modulo 2^32. Opcode 6'b100100 writes reg[rs] + reg[rt] into reg[rd].
- R4: ALU code 3'b110 makes alu_result equal to reg[rs] - operand B in two's complement, modulo 2^32. Opcode 6'b101100 writes reg[rs] - reg[rt] into reg[rd].
- R5: Any other ALU code gives alu_result = 0, and no register is written.
- R6: When opcode bit 5 is 0, no register is written. alu_result still reflects the selected operation.
- R7: When opcode bit 4 is 1, operand B is bits 15:0 of the instruction, sign-extended to 32 bits.
- R8: When opcode bit 0 is 1 and the write is enabled, the destination receives zero.
- R9: probe_r1 always shows register 1. A write to register 1 appears there after the rising edge that performs it, and at no other time does probe_r1 change.
- R10: Reads are combinational and see the register values from before the edge. An instruction whose destination is also a source reads the old value, and the new value is visible from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, loads entry i with i |
| instr | input | 32 | Instruction word executed this cycle |
| alu_result | output | 32 | Combinational ALU output for the current instruction |
| probe_r1 | output | 32 | Current contents of register 1 |

## Verification
The checker relies on instr being a stable, fully known value at each rising edge, because the write address, write data and operands all come from it through combinational paths. The bench changes instr only on the falling edge and samples outputs a short time after it. At reset and between tests it holds a non-writing opcode. Register contents are made visible at the ports with a non-writing add of a register and register 0. For that reason the stimulus never chooses register 0 as a destination, so register 0 always holds zero.

// File: rtl/rtype_pkg.sv
package rtype_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_AW  = 5;
    localparam int IMM_W   = 16;

    // Field positions (the write-back and operand muxes depend on them)
    localparam int OP_LSB = 26;
    localparam int RS_LSB = 21;
    localparam int RT_LSB = 16;
    localparam int RD_LSB = 11;

    typedef enum logic [2:0] {
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110
    } alu_op_e;

    // Opcode bits in order 5..0
    typedef struct packed {
        logic       dst_is_rd;
        logic       b_is_imm;
        logic [2:0] alu_code;
        logic       wb_zero;
    } ctrl_t;

    function automatic logic code_known(logic [2:0] code);
        return (code == ALU_ADD) || (code == ALU_SUB);
    endfunction

endpackage

// File: rtl/rtype_fields.sv
module rtype_fields
    import rtype_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [REG_AW-1:0]  src_a,
    output logic [REG_AW-1:0]  src_b,
    output logic [REG_AW-1:0]  dst,
    output logic [IMM_W-1:0]   imm,
    output logic               wr_en
);

    always_comb begin
        ctrl  = ctrl_t'(instr[INSTR_W-1:OP_LSB]);
        src_a = instr[RS_LSB +: REG_AW];
        src_b = instr[RT_LSB +: REG_AW];
        dst   = ctrl.dst_is_rd ? instr[RD_LSB +: REG_AW] : instr[RT_LSB +: REG_AW];
        imm   = instr[IMM_W-1:0];
        // Only a register-type opcode with a known ALU code commits a result
        wr_en = ctrl.dst_is_rd && code_known(ctrl.alu_code);
    end

endmodule

// File: rtl/rtype_regfile.sv
module rtype_regfile #(
    parameter int DATA_W = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra,
    input  logic [AW-1:0]     rb,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] probe
);

    localparam int NREGS = 1 << AW;

    logic [DATA_W-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= DATA_W'(g);
            end else if (we && (wa == AW'(g))) begin
                regs[g] <= wd;
            end
        end
    end

    assign rd_a  = regs[ra];
    assign rd_b  = regs[rb];
    assign probe = regs[1];

endmodule

// File: rtl/rtype_alu.sv
module rtype_alu
    import rtype_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [2:0]        code,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        case (code)
            ALU_ADD: result = opa + opb;
            ALU_SUB: result = opa - opb;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/rtype_datapath.sv
module rtype_datapath
    import rtype_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    output logic [DATA_W-1:0]  alu_result,
    output logic [DATA_W-1:0]  probe_r1
);

    localparam int EXT_W = DATA_W - IMM_W;

    ctrl_t              ctrl;
    logic [REG_AW-1:0]  src_a;
    logic [REG_AW-1:0]  src_b;
    logic [REG_AW-1:0]  wr_addr;
    logic [IMM_W-1:0]   imm;
    logic               wr_en;
    logic [DATA_W-1:0]  rd_a;
    logic [DATA_W-1:0]  rd_b;
    logic [DATA_W-1:0]  opb;
    logic [DATA_W-1:0]  wr_data;

    rtype_fields u_fields (
        .instr (instr),
        .ctrl  (ctrl),
        .src_a (src_a),
        .src_b (src_b),
        .dst   (wr_addr),
        .imm   (imm),
        .wr_en (wr_en)
    );

    rtype_regfile #(.DATA_W(DATA_W), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (src_a),
        .rb    (src_b),
        .we    (wr_en),
        .wa    (wr_addr),
        .wd    (wr_data),
        .rd_a  (rd_a),
        .rd_b  (rd_b),
        .probe (probe_r1)
    );

    assign opb = ctrl.b_is_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : rd_b;

    rtype_alu #(.DATA_W(DATA_W)) u_alu (
        .opa    (rd_a),
        .opb    (opb),
        .code   (ctrl.alu_code),
        .result (alu_result)
    );

    // Memory stub: the memory-side choice returns zero
    assign wr_data = ctrl.wb_zero ? '0 : alu_result;

endmodule

// File: rtl/rtype_datapath_chk.sv
module rtype_datapath_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] alu_result,
    input logic [DATA_W-1:0] probe_r1,
    input logic [DATA_W-1:0] rd_a,
    input logic [DATA_W-1:0] rd_b,
    input logic              wr_en,
    input logic [4:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] sext_imm;
    assign sext_imm = {{(DATA_W-16){instr[15]}}, instr[15:0]};

    p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[29:27] == 3'b010 && !instr[30]) |-> alu_result == rd_a + rd_b);

    p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[29:27] == 3'b110 && !instr[30]) |-> alu_result == rd_a - rd_b);

    p_other_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[29:27] != 3'b010 && instr[29:27] != 3'b110) |-> (alu_result == '0 && !wr_en));

    p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !instr[31] |-> !wr_en);

    p_imm_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[30] && instr[29:27] == 3'b010) |-> alu_result == rd_a + sext_imm);

    p_wb_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        instr[26] |-> wr_data == '0);

    p_probe_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 5'd1) |=> probe_r1 == $past(wr_data));

    p_probe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 5'd1) |=> $stable(probe_r1));

endmodule

bind rtype_datapath rtype_datapath_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .alu_result (alu_result),
    .probe_r1   (probe_r1),
    .rd_a       (rd_a),
    .rd_b       (rd_b),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
);

// File: tb/rtype_datapath_tb.sv
module rtype_datapath_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] alu_result;
    logic [31:0] probe_r1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] mdl [32];

    always #10 clk = ~clk;   // 50 MHz

    rtype_datapath u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr      (instr),
        .alu_result (alu_result),
        .probe_r1   (probe_r1)
    );

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
        return {op, rs, rt, rd, 11'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Non-writing add of reg k and reg 0 (op 000100) exposes reg k
    task automatic peek(string req, int k, logic [31:0] exp);
        @(negedge clk);
        instr = mk(6'b000100, 5'(k), 5'd0, 5'd0);
        #2;
        check(req, alu_result, exp);
    endtask

    // Apply one instruction, check the ALU output before the edge,
    // then update the model when a write is expected.
    task automatic run(string req, logic [31:0] ins, logic [31:0] exp_alu,
                       bit writes, int dst, logic [31:0] val);
        @(negedge clk);
        instr = ins;
        #2;
        check(req, alu_result, exp_alu);
        @(posedge clk);
        #2;
        if (writes) mdl[dst] = val;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 32; i++) mdl[i] = 32'(i);
        check("R2 probe at reset", probe_r1, 32'd1);
        for (int i = 0; i < 32; i++) peek("R2 reset value", i, 32'(i));
    endtask

    task automatic t_add;
        run("R3 add 5+7", mk(6'b100100, 5'd5, 5'd7, 5'd9), 32'd12, 1, 9, 32'd12);
        peek("R3 add dest r9", 9, 32'd12);
        peek("R1 rt not written", 7, 32'd7);
    endtask

    task automatic t_sub;
        run("R4 sub 4-10", mk(6'b101100, 5'd4, 5'd10, 5'd11), 32'hFFFF_FFFA, 1, 11, 32'hFFFF_FFFA);
        peek("R4 negative wrap r11", 11, 32'hFFFF_FFFA);
        run("R4 sub 20-6", mk(6'b101100, 5'd20, 5'd6, 5'd12), 32'd14, 1, 12, 32'd14);
        peek("R4 dest r12", 12, 32'd14);
        run("R3 add wraps to 0", mk(6'b100100, 5'd11, 5'd6, 5'd17), 32'd0, 1, 17, 32'd0);
        peek("R3 wrap dest r17", 17, 32'd0);
    endtask

    task automatic t_unknown;
        run("R5 code 011 zero", mk(6'b100110, 5'd5, 5'd6, 5'd13), 32'd0, 0, 0, 0);
        peek("R5 r13 untouched", 13, 32'd13);
        run("R5 code 111 zero", mk(6'b101110, 5'd8, 5'd2, 5'd1), 32'd0, 0, 0, 0);
        check("R5 probe untouched", probe_r1, 32'd1);
    endtask

    task automatic t_nowrite;
        run("R6 op5=0 add", mk(6'b000100, 5'd3, 5'd4, 5'd14), 32'd7, 0, 0, 0);
        peek("R6 r14 untouched", 14, 32'd14);
        run("R6 op5=0 sub", mk(6'b001100, 5'd9, 5'd2, 5'd15), 32'd10, 0, 0, 0);
        peek("R6 r15 untouched", 15, 32'd15);
    endtask

    task automatic t_imm;
        // imm 0xFFFE -> -2 ; rd field = 31
        run("R7 imm negative", {6'b110100, 5'd15, 5'd0, 16'hFFFE}, 32'd13, 1, 31, 32'd13);
        peek("R7 dest r31", 31, 32'd13);
        // imm 0x1805 -> +6149 ; rd field = 3
        run("R7 imm positive", {6'b110100, 5'd2, 5'd0, 16'h1805}, 32'd6151, 1, 3, 32'd6151);
        peek("R7 dest r3", 3, 32'd6151);
    endtask

    task automatic t_wbzero;
        run("R8 alu still adds", mk(6'b100101, 5'd5, 5'd6, 5'd16), 32'd11, 1, 16, 32'd0);
        peek("R8 r16 cleared", 16, 32'd0);
    endtask

    task automatic t_probe;
        @(negedge clk);
        instr = mk(6'b100100, 5'd2, 5'd8, 5'd1);
        #2;
        check("R9 probe before edge", probe_r1, 32'd1);
        @(posedge clk);
        #2;
        mdl[1] = 32'd10;
        check("R9 probe after edge", probe_r1, 32'd10);
        run("R9 sub into r1", mk(6'b101100, 5'd1, 5'd4, 5'd1), 32'd6, 1, 1, 32'd6);
        check("R9 probe after sub", probe_r1, 32'd6);
    endtask

    task automatic t_same_reg;
        run("R10 r9+r9 old value", mk(6'b100100, 5'd9, 5'd9, 5'd9), 32'd24, 1, 9, 32'd24);
        run("R10 r9+r9 next cycle", mk(6'b100100, 5'd9, 5'd9, 5'd9), 32'd48, 1, 9, 32'd48);
        peek("R10 r9 final", 9, 32'd48);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 32; i++) peek("R2 R3 R4 final contents", i, mdl[i]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 probe after release", probe_r1, 32'd1);
        t_add;
        t_sub;
        t_unknown;
        t_nowrite;
        t_imm;
        t_wbzero;
        t_probe;
        t_same_reg;
        t_sweep;
        @(negedge clk);
        instr = 32'h0;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule